// File: doc/BRIEF.md
# Serial Host Port for a Calendar Clock

This block is the host side of a calendar clock. A host drives a slow serial clock, a data line, a strobe, a chip select and a 3-bit parallel mode code. The block keeps a shift register that the host fills and empties one bit at a time. It decodes the strobed codes into register-control modes and moves a whole time snapshot into or out of the time counter. It also passes every latched command to the pulse timer. All host pins are asynchronous and are synchronised to a fast system clock. Edges on the serial clock and the strobe are detected in the system clock domain.

There are two command paths. A parallel code other than 111 uses a 40-bit register that carries no year. The parallel code 111 selects the serial path. There the register is 52 bits: 48 data bits and a 4-bit command nibble at the top. The nibble is read as the active command at each strobe, and it can always be shifted. The tri-state data output is modelled as a value plus an enable.

Top module: `rtc_serial_port`

## Requirements
- R1: While the synchronised chip select is low, serial clock edges and strobes change nothing: no shift, no mode change, no command.
- R2: A rising strobe latches the parallel code. A code c other than 111 is reported on `cmd_o` as the nibble {0,c}, with a one-cycle `cmd_vld_o`. The mode it selects stays in force until another strobe.
- R3: With the parallel code 111, a strobe takes register bits [51:48] as the command (bit 48 = command LSB), and `year_en_o` goes high. With any other parallel code, `year_en_o` is low.
- R4: Register layout. Bit 0 is the LSB of the seconds units and leaves first. On the parallel path the data input enters at bit 39. On the serial path it enters at bit 51, and bits [47:0] are the data bits handed to and from the counter.
- R5: In shift mode (command 0001) each rising serial clock edge moves the register one place toward bit 0, and `sdo_o` shows bit 0.
- R6: In hold mode (command 0000) the data bits stay frozen and `sdo_o` follows `sec_sq_i`. On the serial path the command nibble still shifts.
- R7: Time set (command 0010) gives one `cnt_wr_en_o` pulse carrying the register data. `cnt_hold_o` stays high while this mode is in force. The data bits are frozen, and `sdo_o` shows bit 0.
- R8: Time read (command 0011) loads `cnt_rd_i` into bits [47:0], freezes the data bits, and drives `sdo_o` from `sec_sq_i`.
- R9: With `oe_i` low and test mode off, `sdo_en_o` is low. With `oe_i` high, `sdo_en_o` is high.
- R10: Command 1111 sets `test_o`, which forces `sdo_en_o` high. Any other latched command clears it.
- R11: Only commands 00xx change the register mode. Commands 0100 to 1111 leave the register mode as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Host serial clock (asynchronous) |
| sdi_i | input | 1 | Host serial data in |
| stb_i | input | 1 | Host strobe |
| cs_i | input | 1 | Chip select, high = active |
| oe_i | input | 1 | Output enable for the data output |
| mode_i | input | 3 | Parallel mode code |
| sec_sq_i | input | 1 | 1 Hz square wave from the divider |
| cnt_rd_i | input | 48 | Current time counter value |
| sdo_o | output | 1 | Serial data out value |
| sdo_en_o | output | 1 | Data output drive enable (low = high impedance) |
| cnt_wr_o | output | 48 | Data offered to the time counter |
| cnt_wr_en_o | output | 1 | One-cycle write pulse to the counter |
| cnt_hold_o | output | 1 | Hold the time counter |
| year_en_o | output | 1 | Serial path active, year counting enabled |
| cmd_o | output | 4 | Last latched command nibble |
| cmd_vld_o | output | 1 | One-cycle pulse when a command is latched |
| test_o | output | 1 | Test mode active |

## Verification
The checks that run on every cycle cover four things. The data bits stay stable whenever no shift and no counter load is allowed. A counter write never appears outside time-set mode. The command state cannot move while chip select is low. Test mode can only rise on command 1111, and parallel codes never report a command above 0111.

The bench scenarios show the rest. They confirm the bit order end to end, the data refill point on each path, and the round trip of snapshots through time set and time read. They also show that the command nibble shifts while the data is frozen, that pulse-select codes keep the register mode, and how output enable and test mode interact.

// File: rtl/rtc_sp_pkg.sv
// Shared types and codes for the serial host port.
// Assumes command nibbles 00xx form the register-control group.
package rtc_sp_pkg;
    typedef enum logic [1:0] {
        RC_HOLD  = 2'b00,
        RC_SHIFT = 2'b01,
        RC_SET   = 2'b10,
        RC_READ  = 2'b11
    } rc_mode_e;

    localparam logic [2:0] PAR_SERIAL = 3'b111;
    localparam logic [3:0] CMD_SET    = 4'b0010;
    localparam logic [3:0] CMD_READ   = 4'b0011;
    localparam logic [3:0] CMD_TEST   = 4'b1111;
endpackage

// File: rtl/rtc_sp_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous host pins.
// Assumes every bit is a slow level; all bits see the same latency.
module rtc_sp_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the pin values through the synchroniser chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/rtc_sp_dec.sv
// Command decoder: latches parallel codes or serial nibbles on a strobe,
// tracks the register-control mode, test mode and one-shot counter moves.
// Assumes stb_ev_i is already gated by chip select.
module rtc_sp_dec
    import rtc_sp_pkg::*;
#(
    parameter int CMD_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stb_ev_i,
    input  logic [2:0]       par_code_i,
    input  logic [CMD_W-1:0] cmd_field_i,
    output rc_mode_e         rc_mode_o,
    output logic             serial_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic             cmd_vld_o,
    output logic             test_o,
    output logic             set_pulse_o,
    output logic             read_pulse_o
);
    logic [CMD_W-1:0] new_cmd;
    rc_mode_e         rc_q;
    logic             serial_q, test_q, vld_q, set_q, read_q;
    logic [CMD_W-1:0] cmd_q;

    // Select the command source: serial nibble or zero-extended parallel code.
    always_comb begin
        if (par_code_i == PAR_SERIAL) new_cmd = cmd_field_i;
        else                          new_cmd = CMD_W'({1'b0, par_code_i});
    end

    // Latch command state on each accepted strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rc_q     <= RC_HOLD;
            serial_q <= 1'b0;
            test_q   <= 1'b0;
            cmd_q    <= '0;
            vld_q    <= 1'b0;
            set_q    <= 1'b0;
            read_q   <= 1'b0;
        end else begin
            vld_q  <= stb_ev_i;
            set_q  <= stb_ev_i && (new_cmd == CMD_SET);
            read_q <= stb_ev_i && (new_cmd == CMD_READ);
            if (stb_ev_i) begin
                cmd_q    <= new_cmd;
                serial_q <= (par_code_i == PAR_SERIAL);
                test_q   <= (new_cmd == CMD_TEST);
                if (new_cmd[CMD_W-1:2] == '0) rc_q <= rc_mode_e'(new_cmd[1:0]);
            end
        end
    end

    assign rc_mode_o    = rc_q;
    assign serial_o     = serial_q;
    assign cmd_o        = cmd_q;
    assign cmd_vld_o    = vld_q;
    assign test_o       = test_q;
    assign set_pulse_o  = set_q;
    assign read_pulse_o = read_q;

    // R10
    test_from_f_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(test_q) |-> (cmd_q == CMD_TEST));
    // R2
    par_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && !serial_q) |-> (cmd_q[CMD_W-1] == 1'b0));
endmodule

// File: rtl/rtc_sp_shreg.sv
// Host shift register: 40-bit short path or 52-bit long path with a
// command nibble at the top; loads counter snapshots on request.
// Assumes load and shift events never coincide (strobe-separated).
module rtc_sp_shreg
    import rtc_sp_pkg::*;
#(
    parameter int DATA_W  = 48,
    parameter int SHORT_W = 40,
    parameter int CMD_W   = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sh_ev_i,
    input  logic              sdi_i,
    input  logic              serial_i,
    input  rc_mode_e          rc_mode_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [CMD_W-1:0]  cmd_field_o,
    output logic [DATA_W-1:0] data_o,
    output logic              lsb_o
);
    localparam int TOT_W = DATA_W + CMD_W;

    logic [TOT_W-1:0] sr_q;

    // Shift, refill or load the register according to the current mode.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sr_q <= '0;
        end else if (load_i) begin
            sr_q[DATA_W-1:0] <= load_val_i;
        end else if (sh_ev_i) begin
            if (rc_mode_i == RC_SHIFT) begin
                if (serial_i) sr_q <= {sdi_i, sr_q[TOT_W-1:1]};
                else          sr_q[SHORT_W-1:0] <= {sdi_i, sr_q[SHORT_W-1:1]};
            end else if (serial_i) begin
                sr_q[TOT_W-1:DATA_W] <= {sdi_i, sr_q[TOT_W-1:DATA_W+1]};
            end
        end
    end

    assign cmd_field_o = sr_q[TOT_W-1:DATA_W];
    assign data_o      = sr_q[DATA_W-1:0];
    assign lsb_o       = sr_q[0];

    // R6 R7 R8
    data_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !(sh_ev_i && rc_mode_i == RC_SHIFT)) |=> $stable(sr_q[DATA_W-1:0]));
endmodule

// File: rtl/rtc_serial_port.sv
// Top of the host serial port: synchronises host pins, detects serial
// clock and strobe edges under chip select, and drives the data output.
// Assumes the host pins change slowly relative to clk_i.
module rtc_serial_port
    import rtc_sp_pkg::*;
#(
    parameter int DATA_W  = 48,
    parameter int SHORT_W = 40,
    parameter int CMD_W   = 4,
    parameter int STAGES  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              stb_i,
    input  logic              cs_i,
    input  logic              oe_i,
    input  logic [2:0]        mode_i,
    input  logic              sec_sq_i,
    input  logic [DATA_W-1:0] cnt_rd_i,
    output logic              sdo_o,
    output logic              sdo_en_o,
    output logic [DATA_W-1:0] cnt_wr_o,
    output logic              cnt_wr_en_o,
    output logic              cnt_hold_o,
    output logic              year_en_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              cmd_vld_o,
    output logic              test_o
);
    localparam int PIN_W = 7;

    logic [PIN_W-1:0] pins_s;
    logic             sclk_s, sdi_s, stb_s, cs_s;
    logic [2:0]       mode_s;
    logic             sclk_d, stb_d;
    logic             sh_ev, stb_ev;
    rc_mode_e         rc_mode;
    logic             serial, set_p, read_p, lsb;
    logic [CMD_W-1:0] cmd_field;

    rtc_sp_sync #(.W(PIN_W), .STAGES(STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({mode_i, cs_i, stb_i, sdi_i, sclk_i}),
        .sync_o  (pins_s)
    );

    assign {mode_s, cs_s, stb_s, sdi_s, sclk_s} = pins_s;

    // Remember the previous synchronised clock and strobe for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sclk_d <= 1'b0;
            stb_d  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            stb_d  <= stb_s;
        end
    end

    assign sh_ev  = sclk_s && !sclk_d && cs_s;
    assign stb_ev = stb_s && !stb_d && cs_s;

    rtc_sp_dec #(.CMD_W(CMD_W)) dec_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .stb_ev_i     (stb_ev),
        .par_code_i   (mode_s),
        .cmd_field_i  (cmd_field),
        .rc_mode_o    (rc_mode),
        .serial_o     (serial),
        .cmd_o        (cmd_o),
        .cmd_vld_o    (cmd_vld_o),
        .test_o       (test_o),
        .set_pulse_o  (set_p),
        .read_pulse_o (read_p)
    );

    rtc_sp_shreg #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .CMD_W(CMD_W)) sr_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sh_ev_i     (sh_ev),
        .sdi_i       (sdi_s),
        .serial_i    (serial),
        .rc_mode_i   (rc_mode),
        .load_i      (read_p),
        .load_val_i  (cnt_rd_i),
        .cmd_field_o (cmd_field),
        .data_o      (cnt_wr_o),
        .lsb_o       (lsb)
    );

    // Choose the data output source by register mode.
    always_comb begin
        if (rc_mode == RC_SHIFT || rc_mode == RC_SET) sdo_o = lsb;
        else                                          sdo_o = sec_sq_i;
    end

    assign sdo_en_o    = oe_i || test_o;
    assign cnt_wr_en_o = set_p;
    assign cnt_hold_o  = (rc_mode == RC_SET);
    assign year_en_o   = serial;

    // R7
    wr_in_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_wr_en_o |-> cnt_hold_o);
    // R1
    cs_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_s |=> ($stable(cmd_o) && $stable(test_o) && !cmd_vld_o));
endmodule

// File: tb/rtc_serial_port_tb.sv
module rtc_serial_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, stb = 1'b0, cs = 1'b0, oe = 1'b1;
    logic [2:0]  mode = 3'b000;
    logic        sq = 1'b1;
    logic [47:0] cnt_rd = '0;
    logic        sdo, sdo_en, wr_en, hold, year_en, cmd_vld, test;
    logic [47:0] wr_data;
    logic [3:0]  cmd;

    int n_chk = 0, n_fail = 0, wr_cnt = 0;
    logic [47:0] wr_val = '0;
    bit done = 0;

    localparam logic [39:0] P40 = 40'hA5_3C_96_0F_E1;
    localparam logic [47:0] D48 = 48'h98_76_54_32_10_FE;
    localparam logic [47:0] RD48 = 48'h3C_C3_5A_A5_69_96;

    always #2.5 clk = ~clk;

    rtc_serial_port dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .stb_i(stb),
        .cs_i(cs), .oe_i(oe), .mode_i(mode), .sec_sq_i(sq), .cnt_rd_i(cnt_rd),
        .sdo_o(sdo), .sdo_en_o(sdo_en), .cnt_wr_o(wr_data), .cnt_wr_en_o(wr_en),
        .cnt_hold_o(hold), .year_en_o(year_en), .cmd_o(cmd), .cmd_vld_o(cmd_vld),
        .test_o(test)
    );

    // Capture counter writes.
    always @(posedge clk) if (rst_n && wr_en) begin
        wr_cnt++;
        wr_val <= wr_data;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic d);
        @(negedge clk); sdi = d;
        wait_n(6); sclk = 1'b1;
        wait_n(6); sclk = 1'b0;
        wait_n(6);
    endtask

    task automatic strobe(input logic [2:0] c);
        @(negedge clk); mode = c;
        wait_n(6); stb = 1'b1;
        wait_n(6); stb = 1'b0;
        wait_n(10);
    endtask

    task automatic shift_in(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) pulse(v[i]);
    endtask

    task automatic read_out(input int n, output logic [63:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            v[i] = sdo;
            pulse(1'b0);
        end
    endtask

    task automatic t_reset();
        chk("R9 reset enable", sdo_en, 1);
        chk("R6 reset sdo follows 1Hz", sdo, 1);
        chk("R2 reset cmd", cmd, 0);
        chk("R3 reset year", year_en, 0);
        chk("R7 reset hold", hold, 0);
        chk("R10 reset test", test, 0);
    endtask

    task automatic t_par_shift();
        logic [63:0] v;
        cs = 1'b1;
        strobe(3'b001);
        chk("R2 cmd shift", cmd, 4'b0001);
        shift_in(64'(P40), 40);
        chk("R5 lsb visible", sdo, P40[0]);
        read_out(40, v);
        chk("R4 R5 40-bit readout", v[39:0], P40);
    endtask

    task automatic t_time_set();
        logic [63:0] v;
        shift_in(64'(P40), 40);
        strobe(3'b010);
        chk("R7 one write", wr_cnt, 1);
        chk("R7 write data", wr_val[39:0], P40);
        chk("R7 hold", hold, 1);
        chk("R3 short path year", year_en, 0);
        for (int i = 0; i < 8; i++) pulse(1'b1);
        chk("R7 frozen lsb", sdo, P40[0]);
        strobe(3'b001);
        chk("R7 hold released", hold, 0);
        read_out(40, v);
        chk("R7 frozen data", v[39:0], P40);
    endtask

    task automatic t_time_read();
        logic [63:0] v;
        cnt_rd = RD48;
        sq = 1'b0;
        strobe(3'b011);
        chk("R8 sdo 1Hz low", sdo, 0);
        sq = 1'b1;
        wait_n(2);
        chk("R8 sdo 1Hz high", sdo, 1);
        for (int i = 0; i < 5; i++) pulse(1'b1);
        strobe(3'b001);
        read_out(40, v);
        chk("R8 snapshot loaded", v[39:0], RD48[39:0]);
    endtask

    task automatic t_cs_gate();
        cs = 1'b0;
        wait_n(4);
        strobe(3'b000);
        chk("R1 strobe ignored", cmd, 4'b0001);
        for (int i = 0; i < 40; i++) pulse(1'b1);
        cs = 1'b1;
        wait_n(4);
        chk("R1 shift ignored", sdo, 0);
    endtask

    task automatic t_pulse_sel();
        strobe(3'b101);
        chk("R2 pulse code", cmd, 4'b0101);
        shift_in(64'(P40), 40);
        chk("R11 still shifting", sdo, P40[0]);
        pulse(1'b0);
        chk("R11 next bit", sdo, P40[1]);
    endtask

    task automatic t_oe();
        oe = 1'b0;
        wait_n(2);
        chk("R9 disabled", sdo_en, 0);
        oe = 1'b1;
        wait_n(2);
        chk("R9 enabled", sdo_en, 1);
    endtask

    task automatic t_serial();
        logic [63:0] v;
        strobe(3'b111);
        chk("R3 serial cmd from field", cmd, 4'b0000);
        chk("R3 year enabled", year_en, 1);
        sq = 1'b0;
        wait_n(2);
        chk("R6 hold 1Hz", sdo, 0);
        sq = 1'b1;
        shift_in(64'h1, 4);
        strobe(3'b111);
        chk("R6 nibble shifted in hold", cmd, 4'b0001);
        shift_in({12'h0, 4'b0010, D48}, 52);
        strobe(3'b111);
        chk("R3 serial set cmd", cmd, 4'b0010);
        chk("R7 R4 48-bit write", wr_val, D48);
        chk("R7 second write", wr_cnt, 2);
        shift_in(64'hF, 4);
        strobe(3'b111);
        chk("R10 test set", test, 1);
        oe = 1'b0;
        wait_n(2);
        chk("R10 forced enable", sdo_en, 1);
        shift_in(64'h9, 4);
        strobe(3'b111);
        chk("R10 test cleared", test, 0);
        chk("R10 enable released", sdo_en, 0);
        chk("R11 interval keeps set", hold, 1);
        oe = 1'b1;
        shift_in(64'h1, 4);
        strobe(3'b111);
        read_out(48, v);
        chk("R4 48-bit order", v[47:0], D48);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_par_shift();
        t_time_set();
        t_time_read();
        t_cs_gate();
        t_pulse_sel();
        t_oe();
        t_serial();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule